// File: doc/BRIEF.md
# Receive Bit-Error-Rate Alarm Monitor

This block sits behind a receive PCS and watches the per-block error flag the PCS produces. It counts errored blocks inside a repeating window of programmable length. When the count within one window reaches a programmable limit, it raises a high-error-rate alarm. A second, free-running counter keeps the total number of errored blocks seen since reset.

The window length and the limit arrive as plain configuration inputs. They are captured only while reset is held. A change made during normal operation therefore leaves the current window and limit alone until the next reset. An enable input switches the alarm logic on or off. While it is off, the alarm stays low and the window logic rests in its cleared state.

Top module: `ber_watch`

## Requirements
- R1: The window length and limit are sampled from `cfg_window` and `cfg_limit` on every clock edge at which `rst` is high. Values applied while `rst` is low have no effect until the next reset.
- R2: While `mon_en` is high, the window timer advances on every clock, whether or not a block is present. A window lasts `cfg_window` cycles. The in-window error count returns to zero at the edge that closes a window.
- R3: When the in-window count, including an error in the current cycle, reaches the limit, `hi_ber_o` is high from the following clock edge.
- R4: Once set, `hi_ber_o` stays high until the window ends. At the closing edge it takes the result of the window just ended, including an error in its last cycle, and so it drops after a window whose count stayed below the limit.
- R5: An error flag counts only in cycles where `blk_vld` is high. `blk_err` without `blk_vld` changes neither count.
- R6: While `mon_en` is low, `hi_ber_o` is low from the next edge, and the window timer and in-window count are held at zero. Enabling starts a fresh window.
- R7: `err_total_o` rises by one for every valid errored block, whatever the state of `mon_en`. It saturates at all ones and clears only on reset.
- R8: After reset, `hi_ber_o` is 0 and `err_total_o` is 0.
- R9: A window value of 0 or 1 gives a one-cycle window. A limit of 0 counts as reached in every enabled cycle.
- R10: The in-window count saturates at the limit and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| mon_en | input | 1 | Alarm logic enable |
| blk_vld | input | 1 | A received block is present this cycle |
| blk_err | input | 1 | The present block is errored |
| cfg_window | input | 21 | Window length in clock cycles |
| cfg_limit | input | 7 | Errored-block count that raises the alarm |
| hi_ber_o | output | 1 | High error-rate alarm |
| err_total_o | output | TOTAL_W (32) | Saturating total of errored blocks |

## Verification
The case that needs care is an errored block in the last cycle of a window. In that cycle the error that may reach the limit and the window close fall on the same edge. The bench provokes it by sweeping small window lengths and limits with pseudo-random error patterns, so errors regularly land on closing cycles. It also forces the case directly with one-cycle windows. It judges each edge against an arithmetic model in which the closing edge counts the final block for the old window and then starts the new window at zero.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;

    localparam int WIN_W = 21;
    localparam int LIM_W = 7;

    // Captured configuration
    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [LIM_W-1:0] lim;
    } ber_cfg_t;

    // Per-cycle events shared between the sub-blocks
    typedef struct packed {
        logic hit;
        logic expire;
    } ber_evt_t;

    // Window state flag used by the timer
    typedef enum logic {
        WIN_RUN  = 1'b0,
        WIN_LAST = 1'b1
    } win_phase_e;

    // True when the given window length gives a one-cycle window
    function automatic logic win_is_single(input logic [WIN_W-1:0] w);
        return (w <= {{(WIN_W-1){1'b0}}, 1'b1});
    endfunction

    // Add a hit to a count and clamp at the limit
    function automatic logic [LIM_W-1:0] clamp_add(
        input logic [LIM_W-1:0] cnt,
        input logic             hit,
        input logic [LIM_W-1:0] lim
    );
        logic [LIM_W:0] s;
        s = {1'b0, cnt} + {{LIM_W{1'b0}}, hit};
        if (s >= {1'b0, lim})
            return lim;
        return s[LIM_W-1:0];
    endfunction

endpackage

// File: rtl/ber_cfg_hold.sv
module ber_cfg_hold
    import ber_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [LIM_W-1:0] cfg_limit,
    output ber_cfg_t         cfg_q
);
    // Configuration is taken only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.win <= cfg_window;
            cfg_q.lim <= cfg_limit;
        end
    end
endmodule

// File: rtl/ber_win_timer.sv
module ber_win_timer
    import ber_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIN_W-1:0] win_len,
    output logic             expire
);
    logic [WIN_W-1:0] timer_q;
    win_phase_e       phase;

    always_comb begin
        if (win_is_single(win_len) || (timer_q == win_len - {{(WIN_W-1){1'b0}}, 1'b1}))
            phase = WIN_LAST;
        else
            phase = WIN_RUN;
        expire = en && (phase == WIN_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            timer_q <= '0;
        else if (phase == WIN_LAST)
            timer_q <= '0;
        else
            timer_q <= timer_q + {{(WIN_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/ber_win_count.sv
module ber_win_count
    import ber_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ber_evt_t         evt,
    input  logic [LIM_W-1:0] lim,
    output logic [LIM_W-1:0] cnt_q,
    output logic             reach
);
    logic [LIM_W:0] sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + {{LIM_W{1'b0}}, evt.hit};
        reach = en && (sum >= {1'b0, lim});
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (evt.expire)
            cnt_q <= '0;
        else
            cnt_q <= clamp_add(cnt_q, evt.hit, lim);
    end
endmodule

// File: rtl/ber_total_count.sv
module ber_total_count #(
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    output logic [TOTAL_W-1:0] total_q
);
    localparam logic [TOTAL_W-1:0] TOP_VAL = {TOTAL_W{1'b1}};
    localparam logic [TOTAL_W-1:0] ONE     = {{(TOTAL_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            total_q <= '0;
        else if (hit && (total_q != TOP_VAL))
            total_q <= total_q + ONE;
    end
endmodule

// File: rtl/ber_watch.sv
module ber_watch
    import ber_mon_pkg::*;
#(
    parameter int TOTAL_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mon_en,
    input  logic               blk_vld,
    input  logic               blk_err,
    input  logic [WIN_W-1:0]   cfg_window,
    input  logic [LIM_W-1:0]   cfg_limit,
    output logic               hi_ber_o,
    output logic [TOTAL_W-1:0] err_total_o
);
    ber_cfg_t         cfg_q;
    ber_evt_t         evt;
    logic             expire;
    logic             reach;
    logic [LIM_W-1:0] win_cnt;
    logic             hi_q;

    ber_cfg_hold u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_window (cfg_window),
        .cfg_limit  (cfg_limit),
        .cfg_q      (cfg_q)
    );

    ber_win_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (mon_en),
        .win_len (cfg_q.win),
        .expire  (expire)
    );

    always_comb begin
        evt.hit    = blk_vld && blk_err;
        evt.expire = expire;
    end

    ber_win_count u_wcnt (
        .clk   (clk),
        .rst   (rst),
        .en    (mon_en),
        .evt   (evt),
        .lim   (cfg_q.lim),
        .cnt_q (win_cnt),
        .reach (reach)
    );

    ber_total_count #(.TOTAL_W(TOTAL_W)) u_total (
        .clk     (clk),
        .rst     (rst),
        .hit     (evt.hit),
        .total_q (err_total_o)
    );

    // Alarm: set on reach, held to window close, re-judged at close
    always_ff @(posedge clk) begin
        if (rst)
            hi_q <= 1'b0;
        else
            hi_q <= mon_en && (reach || (hi_q && !expire));
    end

    assign hi_ber_o = hi_q;
endmodule

// File: rtl/ber_watch_chk.sv
module ber_watch_chk
    import ber_mon_pkg::*;
#(
    parameter int TOTAL_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               mon_en,
    input logic               blk_vld,
    input logic               blk_err,
    input logic               hi_ber_o,
    input logic [TOTAL_W-1:0] err_total_o,
    input logic               expire,
    input logic               reach,
    input logic [LIM_W-1:0]   win_cnt,
    input ber_cfg_t           cfg_q
);
    bit armed;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        !mon_en |=> (!hi_ber_o && win_cnt == '0));

    assert_total_monotone_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> (err_total_o >= $past(err_total_o)) && (err_total_o - $past(err_total_o) <= 1));

    assert_invalid_ignored_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        !blk_vld |=> $stable(err_total_o));

    assert_window_clears_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        expire |=> win_cnt == '0);

    assert_reach_raises_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (mon_en && reach) |=> hi_ber_o);

    assert_alarm_held_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (mon_en && hi_ber_o && !expire) |=> hi_ber_o);

    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |-> win_cnt <= cfg_q.lim);

    assert_alarm_needs_enable_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(hi_ber_o) |-> $past(mon_en));
endmodule

bind ber_watch ber_watch_chk #(.TOTAL_W(TOTAL_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mon_en      (mon_en),
    .blk_vld     (blk_vld),
    .blk_err     (blk_err),
    .hi_ber_o    (hi_ber_o),
    .err_total_o (err_total_o),
    .expire      (expire),
    .reach       (reach),
    .win_cnt     (win_cnt),
    .cfg_q       (cfg_q)
);

// File: tb/ber_watch_tb_top.sv
module ber_watch_tb_top;
    localparam int CLK_P   = 10;
    localparam int TOT_W   = 6;
    localparam int TOT_MAX = (1 << TOT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mon_en = 1'b0;
    logic             blk_vld = 1'b0;
    logic             blk_err = 1'b0;
    logic [20:0]      cfg_window = 21'd8;
    logic [6:0]       cfg_limit = 7'd3;
    logic             hi_ber_o;
    logic [TOT_W-1:0] err_total_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit done  = 1'b0;

    // reference model state
    int m_win, m_lim, m_timer, m_cnt, m_tot;
    bit m_hi;
    logic [15:0] lf = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    ber_watch #(.TOTAL_W(TOT_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mon_en      (mon_en),
        .blk_vld     (blk_vld),
        .blk_err     (blk_err),
        .cfg_window  (cfg_window),
        .cfg_limit   (cfg_limit),
        .hi_ber_o    (hi_ber_o),
        .err_total_o (err_total_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reset with the given configuration; leaves the bench at a falling edge
    task automatic do_reset(input int w, input int l);
        cfg_window = 21'(w);
        cfg_limit  = 7'(l);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_win = w; m_lim = l; m_timer = 0; m_cnt = 0; m_hi = 0; m_tot = 0;
    endtask

    // One cycle: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge
    task automatic cyc(input bit v, input bit e, input string tag);
        bit hit, last, reach;
        int sum;
        blk_vld = v;
        blk_err = e;
        @(posedge clk);
        hit   = v && e;
        last  = (m_win <= 1) || (m_timer == m_win - 1);
        sum   = m_cnt + int'(hit);
        reach = mon_en && (sum >= m_lim);
        m_hi  = mon_en && (reach || (m_hi && !last));
        if (!mon_en || last) m_timer = 0; else m_timer = m_timer + 1;
        if (!mon_en || last) m_cnt = 0; else m_cnt = (sum >= m_lim) ? m_lim : sum;
        if (hit && m_tot != TOT_MAX) m_tot = m_tot + 1;
        @(negedge clk);
        check(int'(hi_ber_o), int'(m_hi), {tag, " alarm"});
        check(int'(err_total_o), m_tot, "R7 total");
    endtask

    function automatic void lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_n);
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset state
        do_reset(8, 3);
        check(int'(hi_ber_o), 0, "R8 alarm after reset");
        check(int'(err_total_o), 0, "R8 total after reset");

        // R6: disabled, errors counted in total only
        mon_en = 1'b0;
        for (int i = 0; i < 6; i++) cyc(1, 1, "R6");
        check(int'(hi_ber_o), 0, "R6 disabled alarm");
        check(int'(err_total_o), 6, "R7 total while disabled");

        // R3/R4 directed: window 8, limit 2, timer starts at 0
        do_reset(8, 2);
        mon_en = 1'b1;
        cyc(1, 1, "R3");
        check(int'(hi_ber_o), 0, "R3 one error below limit");
        cyc(1, 1, "R3");
        check(int'(hi_ber_o), 1, "R3 limit reached");
        for (int i = 0; i < 5; i++) cyc(0, 0, "R4");
        check(int'(hi_ber_o), 1, "R4 held before close");
        cyc(0, 0, "R4");
        check(int'(hi_ber_o), 1, "R4 window result kept at close");
        for (int i = 0; i < 8; i++) cyc(0, 0, "R4");
        check(int'(hi_ber_o), 0, "R4 drops after clean window");

        // R5: errors without valid are ignored
        do_reset(4, 1);
        mon_en = 1'b1;
        for (int i = 0; i < 6; i++) cyc(0, 1, "R5");
        check(int'(hi_ber_o), 0, "R5 invalid error alarm");
        check(int'(err_total_o), 0, "R5 invalid error total");

        // R2/R4 closing-cycle error: window 4, limit 1, hit on last cycle
        do_reset(4, 1);
        mon_en = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, "R2");
        cyc(1, 1, "R2");
        check(int'(hi_ber_o), 1, "R4 error in closing cycle");
        for (int i = 0; i < 4; i++) cyc(0, 0, "R2");
        check(int'(hi_ber_o), 0, "R2 next window clean");

        // R9: window 0 and 1, limit 0
        for (int w = 0; w < 2; w++) begin
            do_reset(w, 2);
            mon_en = 1'b1;
            cyc(1, 1, "R9");
            check(int'(hi_ber_o), 0, "R9 single-cycle window one error");
            cyc(1, 1, "R9");
            check(int'(hi_ber_o), 0, "R9 count cleared each cycle");
        end
        do_reset(5, 0);
        mon_en = 1'b1;
        cyc(0, 0, "R9");
        check(int'(hi_ber_o), 1, "R9 zero limit");

        // R1: config changes during run take no effect
        do_reset(6, 2);
        mon_en = 1'b1;
        cfg_window = 21'd1;
        cfg_limit  = 7'd1;
        for (int i = 0; i < 40; i++) begin
            lf_step();
            cyc(lf[0], lf[3] & lf[5], "R1");
        end
        do_reset(3, 1);
        mon_en = 1'b1;
        cyc(1, 1, "R1");
        check(int'(hi_ber_o), 1, "R1 new limit after reset");

        // Sweep of windows, limits and error patterns, including enable toggles
        for (int w = 1; w <= 7; w++) begin
            for (int l = 0; l <= 4; l++) begin
                do_reset(w, l);
                for (int i = 0; i < 50; i++) begin
                    lf_step();
                    mon_en = !(lf[7] & lf[9] & lf[11]);
                    cyc(lf[1] | lf[2], lf[4] | lf[6], "R3 R4 R6 R10 sweep");
                end
            end
        end

        // R7 saturation
        do_reset(5, 3);
        mon_en = 1'b1;
        for (int i = 0; i < TOT_MAX + 10; i++) cyc(1, 1, "R7");
        check(int'(err_total_o), TOT_MAX, "R7 saturated total");
        mon_en = 1'b0;
        cyc(1, 1, "R7");
        check(int'(err_total_o), TOT_MAX, "R7 no wrap");
        do_reset(5, 3);
        check(int'(err_total_o), 0, "R7 cleared by reset");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule